// File: doc/BRIEF.md
# Tag Vector Load Unit

This unit carries out a bulk read of 4-bit allocation tags for a memory-tagging scheme. On a start strobe it picks a base address (a general register value, or the stack pointer when the base index is 31). It then reads tags one granule at a time, starting at the 16-byte granule that holds the base address and ending at the top of the aligned group of 16 granules. Each tag lands in the 4-bit slot of a 64-bit result word that its address selects. All other slots stay zero. The unit returns the packed word for the destination register. It also returns a writeback address for the base register: the first granule above the original address that was not read.

Two corner cases can stop the operation. At the user privilege level the unit raises an undefined-instruction indication and does nothing else. When the destination index equals the base index, a per-operation policy input chooses one of four outcomes: suppress the writeback, write back a zero address, raise undefined-instruction, or retire as a no-op.

Top module: `tag_vec_loader`

## Requirements
- R1: After reset, `done`, `undef`, `res_we`, `wb_we` and `tag_rd_en` are all low.
- R2: Reads start at the granule-aligned base address and step up by 16 bytes, one read per cycle. The unit issues exactly 16 − s reads, where s is base address bits [7:4], so the last read is the top granule of the aligned 256-byte group.
- R3: A tag read from address A is placed in result bits [4k+3:4k], where k is A[7:4].
- R4: Result slots below s, which are not loaded, read as zero.
- R5: On normal completion, `wb_we` is high and `wb_addr` is the base address with bits [7:0] cleared, plus 256.
- R6: When `rn_idx` is 31 the base is `sp_val` and `wb_sp` is 1. Otherwise the base is `xn_val` and `wb_sp` is 0. `res_idx` and `wb_idx` echo `rt_idx` and `rn_idx`.
- R7: When `el` is 0 (user level), `done` and `undef` are high together for one cycle. No tag read is issued, and `res_we` and `wb_we` stay low.
- R8: When `rt_idx` equals `rn_idx` and `overlap_mode` is 0, the result is written and `wb_we` stays low.
- R9: When `rt_idx` equals `rn_idx` and `overlap_mode` is 1, the result is written and `wb_we` is high with `wb_addr` equal to 0.
- R10: When `rt_idx` equals `rn_idx` and `overlap_mode` is 2, the outcome is the same as R7.
- R11: When `rt_idx` equals `rn_idx` and `overlap_mode` is 3, `done` pulses with `undef`, `res_we` and `wb_we` low, and no tag read is issued.
- R12: `done` is a single-cycle pulse, and `tag_rd_en` is low in the `done` cycle. A `start` that arrives while an operation is running is ignored, so the result of the running operation is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| el | input | 2 | Privilege level; 0 is user |
| rt_idx | input | 5 | Destination register index |
| rn_idx | input | 5 | Base register index; 31 selects the stack pointer |
| xn_val | input | 64 | Base register value |
| sp_val | input | 64 | Stack pointer value |
| overlap_mode | input | 2 | Policy when rt_idx equals rn_idx: 0 suppress, 1 zero, 2 undefined, 3 no-op |
| tag_rd_en | output | 1 | Tag read request |
| tag_rd_addr | output | 64 | Granule address of the request |
| tag_rd_data | input | 4 | Tag returned one cycle after the request |
| done | output | 1 | Operation finished (one cycle) |
| undef | output | 1 | Undefined-instruction indication, valid with done |
| res_we | output | 1 | Destination write enable, valid with done |
| res_idx | output | 5 | Destination index |
| res_data | output | 64 | Packed tag word |
| wb_we | output | 1 | Base writeback enable, valid with done |
| wb_sp | output | 1 | Writeback targets the stack pointer |
| wb_idx | output | 5 | Base index for writeback |
| wb_addr | output | 64 | Writeback address |

## Verification
The assertions assume that the tag port answers every request on the next cycle, and that `start` is not raised in the cycle right after a trap or no-op completion. This keeps the one-cycle `done` pulse unambiguous. The bench holds `start` for a single cycle per operation and waits out a settling gap after each `done`. Its only mid-operation `start` lands deep inside a 16-read run. Its tag memory model is a registered lookup that always answers one cycle after a request.

// File: rtl/tag_vec_loader.sv
module tag_vec_loader #(
  parameter int ADDR_W    = 64,
  parameter int TAG_W     = 4,
  parameter int SLOTS     = 16,
  parameter int LOG2_GRAN = 4,
  parameter int IDX_W     = 5,
  parameter int EL_W      = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [EL_W-1:0]         el,
  input  logic [IDX_W-1:0]        rt_idx,
  input  logic [IDX_W-1:0]        rn_idx,
  input  logic [ADDR_W-1:0]       xn_val,
  input  logic [ADDR_W-1:0]       sp_val,
  input  logic [1:0]              overlap_mode,
  output logic                    tag_rd_en,
  output logic [ADDR_W-1:0]       tag_rd_addr,
  input  logic [TAG_W-1:0]        tag_rd_data,
  output logic                    done,
  output logic                    undef,
  output logic                    res_we,
  output logic [IDX_W-1:0]        res_idx,
  output logic [TAG_W*SLOTS-1:0]  res_data,
  output logic                    wb_we,
  output logic                    wb_sp,
  output logic [IDX_W-1:0]        wb_idx,
  output logic [ADDR_W-1:0]       wb_addr
);
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int CNT_W   = SLOT_W + 1;
  localparam int GRP_LSB = LOG2_GRAN + SLOT_W;
  localparam int RES_W   = TAG_W * SLOTS;
  localparam logic [IDX_W-1:0]  SP_IDX  = '1;
  localparam logic [CNT_W-1:0]  SLOTS_C = CNT_W'(SLOTS);
  localparam logic [ADDR_W-1:0] GRAN    = ADDR_W'(1) << LOG2_GRAN;
  localparam logic [1:0] OVL_SUPPRESS = 2'd0;
  localparam logic [1:0] OVL_ZERO     = 2'd1;
  localparam logic [1:0] OVL_UNDEF    = 2'd2;
  localparam logic [1:0] OVL_NOP      = 2'd3;

  logic              busy, pend, pend_last, sup_q, zero_q;
  logic [SLOT_W-1:0] pend_slot;
  logic [CNT_W-1:0]  left;
  logic [ADDR_W-1:0] cur;
  logic [RES_W-1:0]  acc, acc_nxt;

  wire               use_sp  = (rn_idx == SP_IDX);
  wire [ADDR_W-1:0]  base    = use_sp ? sp_val : xn_val;
  wire               overlap = (rt_idx == rn_idx);
  wire [SLOT_W-1:0]  first   = base[GRP_LSB-1:LOG2_GRAN];
  wire [CNT_W-1:0]   cnt     = SLOTS_C - CNT_W'(first);
  wire               accept  = start && !busy;
  wire               trap    = (el == '0) || (overlap && overlap_mode == OVL_UNDEF);
  wire               skip    = overlap && overlap_mode == OVL_NOP;

  assign tag_rd_en   = busy && (left != '0);
  assign tag_rd_addr = cur;

  always_comb begin
    acc_nxt = acc;
    if (pend) acc_nxt[pend_slot*TAG_W +: TAG_W] = tag_rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pend      <= 1'b0;
      pend_last <= 1'b0;
      pend_slot <= '0;
      sup_q     <= 1'b0;
      zero_q    <= 1'b0;
      left      <= '0;
      cur       <= '0;
      acc       <= '0;
      done      <= 1'b0;
      undef     <= 1'b0;
      res_we    <= 1'b0;
      res_idx   <= '0;
      res_data  <= '0;
      wb_we     <= 1'b0;
      wb_sp     <= 1'b0;
      wb_idx    <= '0;
      wb_addr   <= '0;
    end else begin
      done   <= 1'b0;
      undef  <= 1'b0;
      res_we <= 1'b0;
      wb_we  <= 1'b0;
      if (accept) begin
        res_idx <= rt_idx;
        wb_idx  <= rn_idx;
        wb_sp   <= use_sp;
        if (trap) begin
          done  <= 1'b1;
          undef <= 1'b1;
        end else if (skip) begin
          done  <= 1'b1;
        end else begin
          busy   <= 1'b1;
          pend   <= 1'b0;
          cur    <= {base[ADDR_W-1:LOG2_GRAN], LOG2_GRAN'(0)};
          left   <= cnt;
          acc    <= '0;
          sup_q  <= overlap && overlap_mode == OVL_SUPPRESS;
          zero_q <= overlap && overlap_mode == OVL_ZERO;
        end
      end else if (busy) begin
        if (left != '0) begin
          pend      <= 1'b1;
          pend_slot <= cur[GRP_LSB-1:LOG2_GRAN];
          pend_last <= (left == CNT_W'(1));
          cur       <= cur + GRAN;
          left      <= left - CNT_W'(1);
        end else begin
          pend <= 1'b0;
        end
        if (pend) acc <= acc_nxt;
        if (pend && pend_last) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          res_we   <= 1'b1;
          res_data <= acc_nxt;
          wb_we    <= !sup_q;
          wb_addr  <= zero_q ? '0 : cur;
        end
      end
    end
  end
endmodule

// File: rtl/tag_vec_loader_chk.sv
module tag_vec_loader_chk #(
  parameter int ADDR_W    = 64,
  parameter int LOG2_GRAN = 4,
  parameter int SLOTS     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tag_rd_en,
  input logic [ADDR_W-1:0] tag_rd_addr,
  input logic              done,
  input logic              undef,
  input logic              res_we,
  input logic              wb_we,
  input logic [ADDR_W-1:0] wb_addr
);
  localparam int GRP_LSB = LOG2_GRAN + $clog2(SLOTS);
  localparam logic [ADDR_W-1:0] GRAN = ADDR_W'(1) << LOG2_GRAN;

  p_rd_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tag_rd_en |-> tag_rd_addr[LOG2_GRAN-1:0] == '0);

  p_rd_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tag_rd_en && $past(tag_rd_en) && $past(rst_n) |-> tag_rd_addr == $past(tag_rd_addr) + GRAN);

  p_next_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we && wb_addr != '0 |-> wb_addr[GRP_LSB-1:0] == '0);

  p_undef_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> done && !res_we && !wb_we && !tag_rd_en);

  p_wb_with_res_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> res_we && done);

  p_done_no_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tag_rd_en);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> !done);
endmodule

bind tag_vec_loader tag_vec_loader_chk #(
  .ADDR_W(ADDR_W), .LOG2_GRAN(LOG2_GRAN), .SLOTS(SLOTS)
) u_chk (.*);

// File: tb/tag_vec_loader_tb.sv
module tag_vec_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  el = 2'd1;
  logic [4:0]  rt_idx = '0, rn_idx = '0;
  logic [63:0] xn_val = '0, sp_val = '0;
  logic [1:0]  overlap_mode = '0;
  logic        tag_rd_en;
  logic [63:0] tag_rd_addr;
  logic [3:0]  tag_rd_data = '0;
  logic        done, undef, res_we, wb_we, wb_sp;
  logic [4:0]  res_idx, wb_idx;
  logic [63:0] res_data, wb_addr;

  int total = 0, bad = 0;

  tag_vec_loader u_dut (.*);

  always #5 clk = ~clk;

  function automatic logic [3:0] tagf(logic [63:0] a);
    return (a[7:4] + a[11:8] + a[15:12]) | 4'h1;
  endfunction

  always @(posedge clk) if (tag_rd_en) tag_rd_data <= tagf(tag_rd_addr);

  int          n_reads, n_done;
  logic        step_bad, prev_en;
  logic [63:0] first_rd, prev_rd;
  logic        c_undef, c_res_we, c_wb_we, c_wb_sp;
  logic [4:0]  c_res_idx, c_wb_idx;
  logic [63:0] c_res, c_wb;

  always @(negedge clk) begin
    if (tag_rd_en) begin
      if (n_reads == 0) first_rd = tag_rd_addr;
      else if (prev_en && tag_rd_addr != prev_rd + 64'd16) step_bad = 1'b1;
      n_reads++;
      prev_rd = tag_rd_addr;
    end
    prev_en = tag_rd_en;
    if (done) begin
      n_done++;
      c_undef = undef; c_res_we = res_we; c_wb_we = wb_we; c_wb_sp = wb_sp;
      c_res_idx = res_idx; c_wb_idx = wb_idx; c_res = res_data; c_wb = wb_addr;
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(logic [1:0] e, logic [4:0] rt, logic [4:0] rn,
                        logic [63:0] xn, logic [63:0] sp, logic [1:0] mode, bit poke);
    logic [63:0] b, grp, exp_res;
    int s;
    bit ovl, trap, skip;
    b    = (rn == 5'd31) ? sp : xn;
    grp  = {b[63:8], 8'h00};
    s    = b[7:4];
    ovl  = (rt == rn);
    trap = (e == 2'd0) || (ovl && mode == 2'd2);
    skip = !trap && ovl && mode == 2'd3;
    exp_res = '0;
    for (int k = s; k < 16; k++) exp_res[k*4 +: 4] = tagf(grp + 64'(k) * 64'd16);

    @(negedge clk);
    n_reads = 0; n_done = 0; step_bad = 1'b0; prev_en = 1'b0;
    el = e; rt_idx = rt; rn_idx = rn; xn_val = xn; sp_val = sp; overlap_mode = mode;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      xn_val = xn ^ 64'h0000_0000_0000_5A50; rt_idx = rt + 5'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int w = 0; w < 60 && n_done == 0; w++) @(negedge clk);
    repeat (4) @(negedge clk);

    chk("R12", "done pulses", 64'(n_done), 64'd1);
    if (trap) begin
      chk(e == 2'd0 ? "R7" : "R10", "undef", 64'(c_undef), 64'd1);
      chk(e == 2'd0 ? "R7" : "R10", "res_we", 64'(c_res_we), 64'd0);
      chk(e == 2'd0 ? "R7" : "R10", "wb_we", 64'(c_wb_we), 64'd0);
      chk(e == 2'd0 ? "R7" : "R10", "reads", 64'(n_reads), 64'd0);
    end else if (skip) begin
      chk("R11", "undef", 64'(c_undef), 64'd0);
      chk("R11", "res_we", 64'(c_res_we), 64'd0);
      chk("R11", "wb_we", 64'(c_wb_we), 64'd0);
      chk("R11", "reads", 64'(n_reads), 64'd0);
    end else begin
      chk("R2", "reads", 64'(n_reads), 64'(16 - s));
      chk("R2", "first read", first_rd, {b[63:4], 4'h0});
      chk("R2", "step error", 64'(step_bad), 64'd0);
      chk("R3", "result", c_res, exp_res);
      if (s > 0) chk("R4", "low slots", c_res & ((64'd1 << (4*s)) - 64'd1), 64'd0);
      chk("R6", "wb_sp", 64'(c_wb_sp), 64'(rn == 5'd31));
      chk("R6", "res_idx", 64'(c_res_idx), 64'(rt));
      chk("R6", "wb_idx", 64'(c_wb_idx), 64'(rn));
      chk("R6", "undef", 64'(c_undef), 64'd0);
      chk("R6", "res_we", 64'(c_res_we), 64'd1);
      if (ovl && mode == 2'd0) begin
        chk("R8", "wb_we", 64'(c_wb_we), 64'd0);
      end else if (ovl && mode == 2'd1) begin
        chk("R9", "wb_we", 64'(c_wb_we), 64'd1);
        chk("R9", "wb_addr", c_wb, 64'd0);
      end else begin
        chk("R5", "wb_we", 64'(c_wb_we), 64'd1);
        chk("R5", "wb_addr", c_wb, grp + 64'd256);
      end
    end
  endtask

  task automatic t_reset;
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "undef", 64'(undef), 64'd0);
    chk("R1", "res_we", 64'(res_we), 64'd0);
    chk("R1", "wb_we", 64'(wb_we), 64'd0);
    chk("R1", "tag_rd_en", 64'(tag_rd_en), 64'd0);
  endtask

  task automatic t_full_group;  run_op(2'd1, 5'd2, 5'd3, 64'h0000_1000_0000_2300, '0, 2'd0, 0); endtask
  task automatic t_mid_group;   run_op(2'd2, 5'd4, 5'd9, 64'h0000_00AB_CDE5_7359, '0, 2'd1, 0); endtask
  task automatic t_last_slot;   run_op(2'd1, 5'd0, 5'd1, 64'h0000_0000_0012_40F7, '0, 2'd0, 0); endtask
  task automatic t_stack_base;  run_op(2'd3, 5'd5, 5'd31, 64'hDEAD_BEEF_0000_0000, 64'h0000_7FFF_FFFF_3A80, 2'd0, 0); endtask
  task automatic t_user_level;  run_op(2'd0, 5'd5, 5'd6, 64'h0000_0000_0000_1230, '0, 2'd0, 0); endtask
  task automatic t_ovl_suppress; run_op(2'd1, 5'd7, 5'd7, 64'h0000_0000_0044_5520, '0, 2'd0, 0); endtask
  task automatic t_ovl_zero;    run_op(2'd1, 5'd7, 5'd7, 64'h0000_0000_0044_55C0, '0, 2'd1, 0); endtask
  task automatic t_ovl_undef;   run_op(2'd1, 5'd7, 5'd7, 64'h0000_0000_0044_5500, '0, 2'd2, 0); endtask
  task automatic t_ovl_nop;     run_op(2'd1, 5'd7, 5'd7, 64'h0000_0000_0044_5500, '0, 2'd3, 0); endtask
  task automatic t_busy_start;  run_op(2'd1, 5'd10, 5'd11, 64'h0000_0003_0000_8800, '0, 2'd0, 1); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_full_group;
    t_mid_group;
    t_last_slot;
    t_stack_base;
    t_user_level;
    t_ovl_suppress;
    t_ovl_zero;
    t_ovl_undef;
    t_ovl_nop;
    t_busy_start;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule